// File: doc/BRIEF.md
# Local Bus Width and Byte-Order Adapter

This block connects a word-wide FIFO interface to a local bus whose data width can be set to 8 bits, 16 bits or the full word. On the outbound path, from FIFO to local bus, each word at the FIFO head is cut into sub-words. The sub-words are handed out on successive local-bus reads, most significant part first, and each one is placed in the low bits of the read bus. On the inbound path, from local bus to FIFO, sub-words written by the local bus are gathered into a full word in the same order. The FIFO advance strobe (outbound) or push strobe (inbound) fires only once every byte of the word has been moved.

A byte-order option applies to both paths:
- no change;
- bytes exchanged inside each halfword;
- the bytes of the word reversed;
- a double-word mode that reverses the bytes of each word and also exchanges the two words of each consecutive pair, using a one-word holding register on each path.

Configuration is meant to change only while both paths are idle. A change of the width setting restarts the sub-word sequence in the same cycle. A change of the byte-order setting empties the pair state.

Top module: `lbw_adapter`

## Requirements
- R1: With `cfg_width` = 0 (8-bit), reads and writes move byte lanes in the order bits [31:24], [23:16], [15:8], [7:0]. The byte sits in `lb_rdata[7:0]` / `lb_wdata[7:0]`, and `lb_rdata[31:8]` reads as zero.
- R2: With `cfg_width` = 1 (16-bit), the first access of a word moves bits [31:16] and the next access moves bits [15:0], alternating. The halfword sits in bits [15:0] of the local data, and `lb_rdata[31:16]` reads as zero.
- R3: With `cfg_width` = 2 (full width), every access moves a whole word.
- R4: When the byte-order mode is not the double-word mode, `ob_adv` is high in exactly the cycle in which a read (`lb_rd` with `lb_rvalid`) takes the last sub-word of the head word, and in no other cycle.
- R5: An inbound word is pushed with `ib_push` high for one cycle, in the cycle after the write strobe that supplies its last sub-word. Bits of `lb_wdata` above the selected width are ignored.
- R6: `cfg_swap` = 0 leaves the byte order unchanged. `cfg_swap` = 1 exchanges the two bytes of each halfword. `cfg_swap` = 2 reverses the four bytes of the word. The setting applies to both paths.
- R7: `cfg_swap` = 3 reverses the bytes of each word and exchanges each consecutive pair of words on both paths. Outbound, the first word of a pair is advanced out of the FIFO into the holding register, the second word is presented first, then the held one. Inbound, the first completed word is held, then the second and the first are pushed on consecutive cycles.
- R8: A change of `cfg_width` restarts the sub-word sequence at the most significant part in the same cycle, on both paths.
- R9: A read strobe while `lb_rvalid` is low has no effect on the sequence or on `ob_adv`.
- R10: During and right after reset, `ob_adv`, `ib_push` and `lb_rvalid` are low while the FIFO shows no data.
- R11: In the double-word mode, a word completed in the cycle in which the held word is being pushed is captured as the first word of the next pair, and no word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 2 | Local bus width: 0 = 8, 1 = 16, 2 = full word |
| cfg_swap | input | 2 | Byte-order mode: 0 none, 1 halfword, 2 word, 3 double word |
| ob_word | input | 32 | Word at the head of the outbound FIFO |
| ob_avail | input | 1 | Outbound FIFO holds a word |
| ob_adv | output | 1 | Advance the outbound FIFO read pointer |
| lb_rd | input | 1 | Local bus read strobe |
| lb_rdata | output | 32 | Local bus read data, sub-word in the low bits |
| lb_rvalid | output | 1 | Read data is present |
| lb_wr | input | 1 | Local bus write strobe |
| lb_wdata | input | 32 | Local bus write data, sub-word in the low bits |
| ib_push | output | 1 | Push a completed word into the inbound FIFO |
| ib_word | output | 32 | Word pushed into the inbound FIFO |

## Verification
In the double-word mode at full width, the push of the held word and the capture of a new first word fall in the same cycle when a write strobe arrives in every cycle. A segment with every strobe forced on provokes this. Pushed words are compared, in order, with a list built from the written words by pair exchange and byte reversal, so a dropped or duplicated word shows up as a mismatch. On the outbound side, a width change falling in the same cycle as a read is provoked directly after one byte has been read, and the returned halfword and the advance strobe are checked.

// File: rtl/lbw_pkg.sv
package lbw_pkg;
   typedef enum logic [1:0] {
      BW_8    = 2'd0,
      BW_16   = 2'd1,
      BW_FULL = 2'd2,
      BW_RSVD = 2'd3
   } bus_w_e;

   typedef enum logic [1:0] {
      SW_NONE = 2'd0,
      SW_HALF = 2'd1,
      SW_WORD = 2'd2,
      SW_PAIR = 2'd3
   } swap_e;

   typedef enum logic [1:0] {
      PR_EMPTY = 2'd0,
      PR_HELD  = 2'd1,
      PR_DRAIN = 2'd2
   } pair_e;
endpackage

// File: rtl/lbw_swap.sv
module lbw_swap
   import lbw_pkg::*;
#(
   parameter int LANES = 4,
   localparam int DW = LANES * 8
) (
   input  logic [DW-1:0] din,
   input  swap_e         mode,
   output logic [DW-1:0] dout
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int PAIR_L = i ^ 1;
      localparam int REV_L  = LANES - 1 - i;
      assign dout[i*8 +: 8] = (mode == SW_NONE) ? din[i*8 +: 8] :
                              (mode == SW_HALF) ? din[PAIR_L*8 +: 8] :
                                                  din[REV_L*8 +: 8];
   end
endmodule

// File: rtl/lbw_seq.sv
module lbw_seq
   import lbw_pkg::*;
#(
   parameter int LANES = 4,
   localparam int PH_W = $clog2(LANES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  bus_w_e          width,
   input  logic            step,
   output logic [PH_W-1:0] phase,
   output logic            last
);
   bus_w_e          width_q;
   logic [PH_W-1:0] phase_q;
   logic [PH_W-1:0] top_ph;

   always_comb begin
      case (width)
         BW_8:    top_ph = PH_W'(LANES - 1);
         BW_16:   top_ph = PH_W'(LANES / 2 - 1);
         default: top_ph = '0;
      endcase
   end

   assign phase = (width != width_q) ? '0 : phase_q;
   assign last  = (phase == top_ph);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         width_q <= BW_8;
         phase_q <= '0;
      end else begin
         width_q <= width;
         if (step) phase_q <= last ? '0 : phase + PH_W'(1);
         else      phase_q <= phase;
      end
   end

   // R8
   phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((width != width_q) && !step) |=> (phase_q == '0));
endmodule

// File: rtl/lbw_rd_path.sv
module lbw_rd_path
   import lbw_pkg::*;
#(
   parameter int LANES = 4,
   localparam int DW   = LANES * 8,
   localparam int PH_W = $clog2(LANES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  bus_w_e        width,
   input  swap_e         swap,
   input  logic [DW-1:0] ob_word,
   input  logic          ob_avail,
   output logic          ob_adv,
   input  logic          lb_rd,
   output logic [DW-1:0] lb_rdata,
   output logic          lb_rvalid
);
   logic [DW-1:0]   head_sw;
   logic [DW-1:0]   hold_q;
   logic [DW-1:0]   src;
   logic [PH_W-1:0] phase;
   logic            last;
   logic            take;
   logic            pair_on;
   pair_e           pst_q;
   pair_e           pst_eff;
   swap_e           swap_q;
   int              s8;
   int              s16;

   lbw_swap #(.LANES(LANES)) u_swap (.din(ob_word), .mode(swap), .dout(head_sw));

   assign take    = lb_rd & lb_rvalid;
   assign pair_on = (swap == SW_PAIR);
   assign pst_eff = (swap != swap_q) ? PR_EMPTY : pst_q;

   lbw_seq #(.LANES(LANES)) u_seq (
      .clk(clk), .rst_n(rst_n), .width(width), .step(take),
      .phase(phase), .last(last)
   );

   always_comb begin
      if (!pair_on) begin
         src       = head_sw;
         lb_rvalid = ob_avail;
         ob_adv    = take & last;
      end else begin
         case (pst_eff)
            PR_EMPTY: begin
               src       = head_sw;
               lb_rvalid = 1'b0;
               ob_adv    = ob_avail;
            end
            PR_HELD: begin
               src       = head_sw;
               lb_rvalid = ob_avail;
               ob_adv    = take & last;
            end
            default: begin
               src       = hold_q;
               lb_rvalid = 1'b1;
               ob_adv    = 1'b0;
            end
         endcase
      end
   end

   always_comb begin
      s8       = LANES - 1 - int'(phase);
      s16      = LANES / 2 - 1 - int'(phase);
      lb_rdata = '0;
      case (width)
         BW_8:    lb_rdata[7:0]  = src[s8*8 +: 8];
         BW_16:   lb_rdata[15:0] = src[s16*16 +: 16];
         default: lb_rdata       = src;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pst_q  <= PR_EMPTY;
         hold_q <= '0;
         swap_q <= SW_NONE;
      end else begin
         swap_q <= swap;
         pst_q  <= pst_eff;
         if (!pair_on) begin
            pst_q <= PR_EMPTY;
         end else begin
            case (pst_eff)
               PR_EMPTY: if (ob_avail) begin
                  hold_q <= head_sw;
                  pst_q  <= PR_HELD;
               end
               PR_HELD:  if (take && last) pst_q <= PR_DRAIN;
               default:  if (take && last) pst_q <= PR_EMPTY;
            endcase
         end
      end
   end

   // R4
   adv_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ob_adv && !pair_on) |=> (phase == '0));

   // R7
   drain_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_on && (pst_eff == PR_HELD) && ob_adv) |=> ((swap != swap_q) || lb_rvalid));
endmodule

// File: rtl/lbw_wr_path.sv
module lbw_wr_path
   import lbw_pkg::*;
#(
   parameter int LANES = 4,
   localparam int DW   = LANES * 8,
   localparam int PH_W = $clog2(LANES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  bus_w_e        width,
   input  swap_e         swap,
   input  logic          lb_wr,
   input  logic [DW-1:0] lb_wdata,
   output logic          ib_push,
   output logic [DW-1:0] ib_word
);
   logic [DW-1:0]   acc_q;
   logic [DW-1:0]   hold_q;
   logic [DW-1:0]   placed;
   logic [DW-1:0]   done_sw;
   logic [PH_W-1:0] phase;
   logic            last;
   logic            done;
   logic            pair_on;
   pair_e           wst_q;
   pair_e           wst_eff;
   swap_e           swap_q;
   int              s8;
   int              s16;

   lbw_seq #(.LANES(LANES)) u_seq (
      .clk(clk), .rst_n(rst_n), .width(width), .step(lb_wr),
      .phase(phase), .last(last)
   );

   always_comb begin
      s8     = LANES - 1 - int'(phase);
      s16    = LANES / 2 - 1 - int'(phase);
      placed = acc_q;
      case (width)
         BW_8:    placed[s8*8 +: 8]    = lb_wdata[7:0];
         BW_16:   placed[s16*16 +: 16] = lb_wdata[15:0];
         default: placed               = lb_wdata;
      endcase
   end

   lbw_swap #(.LANES(LANES)) u_swap (.din(placed), .mode(swap), .dout(done_sw));

   assign done    = lb_wr & last;
   assign pair_on = (swap == SW_PAIR);
   assign wst_eff = (swap != swap_q) ? PR_EMPTY : wst_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         hold_q  <= '0;
         ib_push <= 1'b0;
         ib_word <= '0;
         wst_q   <= PR_EMPTY;
         swap_q  <= SW_NONE;
      end else begin
         swap_q  <= swap;
         ib_push <= 1'b0;
         wst_q   <= wst_eff;
         if (lb_wr) acc_q <= placed;
         if (!pair_on) begin
            wst_q <= PR_EMPTY;
            if (done) begin
               ib_push <= 1'b1;
               ib_word <= done_sw;
            end
         end else begin
            case (wst_eff)
               PR_EMPTY: if (done) begin
                  hold_q <= done_sw;
                  wst_q  <= PR_HELD;
               end
               PR_HELD: if (done) begin
                  ib_push <= 1'b1;
                  ib_word <= done_sw;
                  wst_q   <= PR_DRAIN;
               end
               default: begin
                  ib_push <= 1'b1;
                  ib_word <= hold_q;
                  if (done) begin
                     hold_q <= done_sw;
                     wst_q  <= PR_HELD;
                  end else begin
                     wst_q  <= PR_EMPTY;
                  end
               end
            endcase
         end
      end
   end

   // R5
   push_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pair_on && done) |=> ib_push);

   // R11
   drain_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_on && (wst_eff == PR_DRAIN) && done) |=> (ib_push && (wst_q == PR_HELD)));
endmodule

// File: rtl/lbw_adapter.sv
module lbw_adapter
   import lbw_pkg::*;
#(
   parameter int LANES = 4,
   localparam int DW = LANES * 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    cfg_width,
   input  logic [1:0]    cfg_swap,
   input  logic [DW-1:0] ob_word,
   input  logic          ob_avail,
   output logic          ob_adv,
   input  logic          lb_rd,
   output logic [DW-1:0] lb_rdata,
   output logic          lb_rvalid,
   input  logic          lb_wr,
   input  logic [DW-1:0] lb_wdata,
   output logic          ib_push,
   output logic [DW-1:0] ib_word
);
   if (LANES < 4 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("lbw_adapter: LANES must be a power of two, at least 4");
   end

   bus_w_e width;
   swap_e  swap;

   assign width = bus_w_e'(cfg_width);
   assign swap  = swap_e'(cfg_swap);

   lbw_rd_path #(.LANES(LANES)) u_rd (
      .clk(clk), .rst_n(rst_n), .width(width), .swap(swap),
      .ob_word(ob_word), .ob_avail(ob_avail), .ob_adv(ob_adv),
      .lb_rd(lb_rd), .lb_rdata(lb_rdata), .lb_rvalid(lb_rvalid)
   );

   lbw_wr_path #(.LANES(LANES)) u_wr (
      .clk(clk), .rst_n(rst_n), .width(width), .swap(swap),
      .lb_wr(lb_wr), .lb_wdata(lb_wdata),
      .ib_push(ib_push), .ib_word(ib_word)
   );
endmodule

// File: tb/lbw_adapter_tb_top.sv
module lbw_adapter_tb_top;
   localparam int LANES = 4;
   localparam int DW    = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [1:0]    cfg_width;
   logic [1:0]    cfg_swap;
   logic [DW-1:0] ob_word;
   logic          ob_avail;
   logic          ob_adv;
   logic          lb_rd;
   logic [DW-1:0] lb_rdata;
   logic          lb_rvalid;
   logic          lb_wr;
   logic [DW-1:0] lb_wdata;
   logic          ib_push;
   logic [DW-1:0] ib_word;
   int            n_chk  = 0;
   int            n_fail = 0;

   always #5 clk = ~clk;

   lbw_adapter #(.LANES(LANES)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_swap(cfg_swap),
      .ob_word(ob_word), .ob_avail(ob_avail), .ob_adv(ob_adv),
      .lb_rd(lb_rd), .lb_rdata(lb_rdata), .lb_rvalid(lb_rvalid),
      .lb_wr(lb_wr), .lb_wdata(lb_wdata), .ib_push(ib_push), .ib_word(ib_word)
   );

   function automatic logic [DW-1:0] bswap(input logic [DW-1:0] w, input int sw);
      case (sw)
         0:       return w;
         1:       return {w[23:16], w[31:24], w[7:0], w[15:8]};
         default: return {w[7:0], w[15:8], w[23:16], w[31:24]};
      endcase
   endfunction

   function automatic int nsub(input int wd);
      return (wd == 0) ? 4 : (wd == 1) ? 2 : 1;
   endfunction

   function automatic logic [DW-1:0] subw(input logic [DW-1:0] w, input int wd, input int k);
      case (wd)
         0:       return {24'h0, w[31-8*k -: 8]};
         1:       return {16'h0, w[31-16*k -: 16]};
         default: return w;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic idle();
      ob_avail = 1'b0;
      ob_word  = '0;
      lb_rd    = 1'b0;
      lb_wr    = 1'b0;
      lb_wdata = '0;
   endtask

   task automatic run_seg(input int wd, input int sw, input int nw, input int rd_pct,
                          input int wr_pct, input int av_pct);
      logic [DW-1:0] rq[$];
      logic [DW-1:0] rexp[$];
      logic [DW-1:0] wsub[$];
      logic [DW-1:0] wexp[$];
      logic [DW-1:0] rw[16];
      logic [DW-1:0] bw[16];
      logic [DW-1:0] e;
      logic [DW-1:0] junk;
      int            pops;
      int            rk;
      int            cyc;
      bit            pend;
      bit            exp_adv;
      string         rtag;
      string         wtag;
      pops = 0;
      rk   = 0;
      cyc  = 0;
      pend = 1'b0;
      if (sw == 3)      rtag = "R7";
      else if (sw != 0) rtag = "R6";
      else if (wd == 0) rtag = "R1";
      else if (wd == 1) rtag = "R2";
      else              rtag = "R3";
      wtag = (sw == 3 && wd == 2 && wr_pct == 100) ? "R11" : "R5";
      for (int i = 0; i < nw; i++) begin
         rw[i] = $urandom;
         bw[i] = $urandom;
         rq.push_back(rw[i]);
      end
      for (int i = 0; i < nw; i++) begin
         int src_i;
         src_i = (sw == 3) ? (i ^ 1) : i;
         for (int k = 0; k < nsub(wd); k++) begin
            rexp.push_back(subw(bswap(rw[src_i], sw), wd, k));
            junk = $urandom;
            if (wd == 0)      junk = junk & 32'hFFFF_FF00;
            else if (wd == 1) junk = junk & 32'hFFFF_0000;
            else              junk = '0;
            wsub.push_back(subw(bw[i], wd, k) | junk);
         end
         wexp.push_back(bswap(bw[src_i], sw));
      end
      @(negedge clk);
      idle();
      cfg_width = 2'(wd);
      cfg_swap  = 2'(sw);
      while ((rexp.size() > 0 || wsub.size() > 0 || wexp.size() > 0) && cyc < 4000) begin
         @(negedge clk);
         cyc++;
         if (pend) begin
            void'(rq.pop_front());
            pend = 1'b0;
         end
         if (ib_push) begin
            if (wexp.size() == 0) chk(1'b0, wtag, ib_word, '0);
            else begin
               e = wexp.pop_front();
               chk(ib_word == e, wtag, ib_word, e);
            end
         end
         ob_avail = (rq.size() > 0) && (($urandom % 100) < av_pct);
         ob_word  = (rq.size() > 0) ? rq[0] : $urandom;
         lb_rd    = (($urandom % 100) < rd_pct);
         lb_wr    = (wsub.size() > 0) && (($urandom % 100) < wr_pct);
         lb_wdata = lb_wr ? wsub[0] : $urandom;
         #1;
         exp_adv = 1'b0;
         if (lb_rd && lb_rvalid) begin
            rk++;
            if (rk == nsub(wd)) begin
               rk      = 0;
               exp_adv = 1'b1;
            end
            if (rexp.size() == 0) chk(1'b0, rtag, lb_rdata, '0);
            else begin
               e = rexp.pop_front();
               chk(lb_rdata == e, rtag, lb_rdata, e);
            end
         end
         if (sw != 3) chk(ob_adv == exp_adv, "R4", 32'(ob_adv), 32'(exp_adv));
         if (ob_adv) begin
            pops++;
            pend = 1'b1;
         end
         if (lb_wr) void'(wsub.pop_front());
      end
      @(negedge clk);
      if (pend) void'(rq.pop_front());
      idle();
      chk(pops == nw, "R4", 32'(pops), 32'(nw));
      chk(rq.size() == 0, "R4", 32'(rq.size()), 32'd0);
      chk(cyc < 4000, rtag, 32'(cyc), 32'd4000);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", n_fail);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd4517));
      rst_n     = 1'b0;
      cfg_width = 2'd0;
      cfg_swap  = 2'd0;
      idle();
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(ob_adv == 1'b0, "R10", 32'(ob_adv), 32'd0);
      chk(ib_push == 1'b0, "R10", 32'(ib_push), 32'd0);
      chk(lb_rvalid == 1'b0, "R10", 32'(lb_rvalid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ib_push == 1'b0, "R10", 32'(ib_push), 32'd0);
      chk(lb_rvalid == 1'b0, "R10", 32'(lb_rvalid), 32'd0);

      // R8 outbound: one byte, then switch to 16-bit mid-word
      ob_word  = 32'hA1B2_C3D4;
      ob_avail = 1'b1;
      lb_rd    = 1'b1;
      #1;
      chk(lb_rdata == 32'h0000_00A1, "R1", lb_rdata, 32'h0000_00A1);
      chk(ob_adv == 1'b0, "R4", 32'(ob_adv), 32'd0);
      @(negedge clk);
      cfg_width = 2'd1;
      #1;
      chk(lb_rdata == 32'h0000_A1B2, "R8", lb_rdata, 32'h0000_A1B2);
      chk(ob_adv == 1'b0, "R8", 32'(ob_adv), 32'd0);
      @(negedge clk);
      #1;
      chk(lb_rdata == 32'h0000_C3D4, "R2", lb_rdata, 32'h0000_C3D4);
      chk(ob_adv == 1'b1, "R4", 32'(ob_adv), 32'd1);
      @(negedge clk);
      idle();

      // R9: reads while nothing is valid are ignored
      lb_rd = 1'b1;
      #1;
      chk(lb_rvalid == 1'b0, "R9", 32'(lb_rvalid), 32'd0);
      chk(ob_adv == 1'b0, "R9", 32'(ob_adv), 32'd0);
      repeat (2) @(negedge clk);
      lb_rd    = 1'b0;
      ob_avail = 1'b1;
      ob_word  = 32'h0BAD_F00D;
      #1;
      chk(lb_rdata == 32'h0000_0BAD, "R9", lb_rdata, 32'h0000_0BAD);
      lb_rd = 1'b1;
      @(negedge clk);
      #1;
      chk(lb_rdata == 32'h0000_F00D, "R9", lb_rdata, 32'h0000_F00D);
      chk(ob_adv == 1'b1, "R9", 32'(ob_adv), 32'd1);
      @(negedge clk);
      idle();

      // R8 inbound: one byte at 8-bit, then two halfwords at 16-bit
      cfg_width = 2'd0;
      @(negedge clk);
      lb_wr    = 1'b1;
      lb_wdata = 32'hFFFF_FF11;
      @(negedge clk);
      chk(ib_push == 1'b0, "R8", 32'(ib_push), 32'd0);
      cfg_width = 2'd1;
      lb_wdata  = 32'hFFFF_5566;
      @(negedge clk);
      chk(ib_push == 1'b0, "R8", 32'(ib_push), 32'd0);
      lb_wdata = 32'h0000_7788;
      @(negedge clk);
      idle();
      chk(ib_push == 1'b1, "R5", 32'(ib_push), 32'd1);
      chk(ib_word == 32'h5566_7788, "R8", ib_word, 32'h5566_7788);
      @(negedge clk);
      chk(ib_push == 1'b0, "R5", 32'(ib_push), 32'd0);

      // directed modes
      run_seg(0, 0, 8, 70, 70, 80);
      run_seg(1, 0, 8, 70, 70, 80);
      run_seg(2, 0, 8, 70, 70, 80);
      run_seg(0, 1, 6, 60, 60, 90);
      run_seg(2, 2, 6, 60, 60, 90);
      run_seg(0, 3, 8, 70, 70, 80);
      run_seg(1, 3, 8, 70, 70, 80);
      // R11: every strobe on, full width, double-word mode
      run_seg(2, 3, 16, 100, 100, 100);
      // constrained random
      for (int s = 0; s < 24; s++) begin
         run_seg(int'($urandom % 3), int'($urandom % 4), 2 * (1 + int'($urandom % 8)),
                 30 + int'($urandom % 71), 30 + int'($urandom % 71), 40 + int'($urandom % 61));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule